// File: doc/BRIEF.md
# SD/MMC Command Path

This block is the command half of a memory-card host controller. Software loads a 32-bit command argument as two 16-bit halves and then writes a 16-bit command word. The block builds a 48-bit command frame, appends a CRC7, and shifts the frame out on the card command line. When the command expects an answer, the block listens for the card's response, deserialises it, checks its CRC, and places the result into eight 16-bit response words. Three sticky status bits report completion, a missing response and a corrupted response. Software clears them by writing ones.

The card clock comes from the system clock through a fixed divider and runs all the time. The block drives the command line on the falling card-clock edge and samples it on the rising edge. A dedicated command word asks for initialisation clocks only: the block holds the line high for a fixed number of card clocks and then reports completion.

Register offsets on the write port: command word 0x00, argument low half 0x04, argument high half 0x08, status 0x10. Command word fields: opcode in bits 5:0, response kind in bits 9:8, command kind in bits 13:12.

Top module: `sdc_cmd_path`

## Requirements
- R1: After reset, `status` is 0, `busy` is 0, `cmd_oe` is 0, `cmd_out` is 1 and `rsp_regs` is 0.
- R2: A command write sends 48 bits MSB first, changing `cmd_out` only on falling card-clock edges. The bits are: 0, 1, opcode[5:0], argument[31:0], CRC7 (polynomial x^7+x^3+1, initial value 0) over the preceding 40 bits, and 1.
- R3: `cmd_oe` is high exactly while the block drives a frame or the initialisation clocks, and it falls one card clock after the last bit.
- R4: The command word 0x0080 drives `cmd_out` high for INIT_CLKS card clocks, does not wait for a response, and then sets status bit 0 (end of command).
- R5: Capture begins at the first rising card-clock edge that samples `cmd_in` low. With response kind 1 (short, 48 bits), bits 39:8 of the response go to word 7 (high half) and word 6 (low half), and words 0..5 become 0. Status bit 0 is then set.
- R6: With response kind 2 (long, 136 bits), the 128 bits that follow the first 8 response bits are stored with word 2k+1:2k holding bits 32k+31:32k, so the last received bit lands in bit 0 of word 0.
- R7: A CRC7 mismatch sets status bit 8 together with bit 0. For a short response, the CRC covers the first 40 bits. For a long response, it covers the 120 bits after the 8-bit header.
- R8: Response kind 3 (short, no CRC) never sets status bit 8.
- R9: If TIMEOUT rising card-clock edges pass after the frame without a start bit, status bit 7 (timeout) is set, bit 0 stays clear, and `busy` falls.
- R10: Response kind 0, or command kind 0 (broadcast, no response) with any response kind, finishes right after the frame with status bit 0 and no wait.
- R11: A command-word write while `busy` is high is ignored: it sends no frame.
- R12: Writing the status offset clears each status bit whose data bit is 1. A status event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register byte offset |
| wr_data | input | 16 | Register write data |
| status | output | 16 | Sticky status: bit 0 end of command, bit 7 timeout, bit 8 CRC error |
| busy | output | 1 | Command in progress |
| rsp_regs | output | 128 | Response words, word i at bits 16i+15:16i |
| card_clk | output | 1 | Card clock |
| cmd_out | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line output enable |
| cmd_in | input | 1 | Command line input |

## Verification
The bench builds the block with HALF_DIV=2, so one card clock lasts four system clocks. It sets TIMEOUT=16, which lets a run with no reply reach the timeout within a few hundred cycles. INIT_CLKS stays at 80, so the full initialisation burst length is measured directly. A card model samples every burst on the rising card clock and answers with short, long, corrupted and CRC-less responses. These cover every response packing and the CRC check windows.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int FRAME_W = 48;
  localparam int LONG_W  = 136;
  localparam int RSP_W   = 128;

  typedef enum logic [1:0] {
    RSP_NONE        = 2'd0,
    RSP_SHORT       = 2'd1,
    RSP_LONG        = 2'd2,
    RSP_SHORT_NOCRC = 2'd3
  } rsp_kind_e;

  typedef enum logic [1:0] {
    CT_BC   = 2'd0,
    CT_BCR  = 2'd1,
    CT_AC   = 2'd2,
    CT_ADTC = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_RX   = 2'd2
  } path_state_e;

  // one serial step of CRC7, polynomial x^7 + x^3 + 1
  function automatic logic [6:0] crc7_next(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [6:0] crc7_of40(input logic [39:0] v);
    logic [6:0] c;
    c = '0;
    for (int i = 39; i >= 0; i--) c = crc7_next(c, v[i]);
    return c;
  endfunction
endpackage

// File: rtl/sdc_clkgen.sv
module sdc_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic card_clk,
  output logic fall_tick,
  output logic rise_tick
);
  localparam int CW = $clog2(HALF_DIV) + 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap      = (cnt == CW'(HALF_DIV - 1));
  assign fall_tick = wrap & card_clk;
  assign rise_tick = wrap & ~card_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      card_clk <= 1'b0;
    end else if (wrap) begin
      cnt      <= '0;
      card_clk <= ~card_clk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sdc_cmd_tx.sv
module sdc_cmd_tx import sdc_pkg::*; #(
  parameter int INIT_CLKS = 80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fall_tick,
  input  logic               start,
  input  logic               init_mode,
  input  logic [FRAME_W-1:0] frame,
  output logic               cmd_bit,
  output logic               cmd_oe,
  output logic               done
);
  localparam int CW = $clog2(INIT_CLKS + FRAME_W) + 1;

  logic [FRAME_W-1:0] sr;
  logic [CW-1:0]      left;
  logic               active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      left    <= '0;
      active  <= 1'b0;
      cmd_bit <= 1'b1;
      cmd_oe  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sr     <= init_mode ? '1 : frame;
        left   <= init_mode ? CW'(INIT_CLKS) : CW'(FRAME_W);
        active <= 1'b1;
      end else if (active && fall_tick) begin
        if (left == '0) begin
          active  <= 1'b0;
          cmd_oe  <= 1'b0;
          cmd_bit <= 1'b1;
          done    <= 1'b1;
        end else begin
          cmd_oe  <= 1'b1;
          cmd_bit <= sr[FRAME_W-1];
          sr      <= {sr[FRAME_W-2:0], 1'b1};
          left    <= left - 1'b1;
        end
      end
    end
  end

  // R2: the line value moves only on a falling card-clock edge
  a_r2_fall_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_tick |=> $stable(cmd_bit));
endmodule

// File: rtl/sdc_rsp_rx.sv
module sdc_rsp_rx import sdc_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_tick,
  input  logic             arm,
  input  logic             long_mode,
  input  logic             cmd_in,
  output logic             started,
  output logic             done,
  output logic             crc_ok,
  output logic [RSP_W-1:0] shreg
);
  logic [7:0] cnt;
  logic [6:0] crc;
  logic       fin;
  logic [7:0] last_idx;
  logic       covered;

  assign last_idx = long_mode ? 8'(LONG_W - 1) : 8'(FRAME_W - 1);
  assign covered  = long_mode ? (cnt >= 8'd8 && cnt < 8'd128) : (cnt < 8'd40);
  assign crc_ok   = (crc == shreg[7:1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      done    <= 1'b0;
      fin     <= 1'b0;
      cnt     <= '0;
      crc     <= '0;
      shreg   <= '0;
    end else begin
      done <= 1'b0;
      if (!arm) begin
        started <= 1'b0;
        fin     <= 1'b0;
        cnt     <= '0;
        crc     <= '0;
      end else if (rise_tick && !fin) begin
        if (!started) begin
          if (!cmd_in) begin
            started <= 1'b1;
            cnt     <= 8'd1;
            crc     <= '0;
            shreg   <= {shreg[RSP_W-2:0], 1'b0};
          end
        end else begin
          shreg <= {shreg[RSP_W-2:0], cmd_in};
          if (covered) crc <= crc7_next(crc, cmd_in);
          cnt <= cnt + 1'b1;
          if (cnt == last_idx) begin
            done    <= 1'b1;
            fin     <= 1'b1;
            started <= 1'b0;
          end
        end
      end
    end
  end

  // R5: capture opens only on a low start bit
  a_r5_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(started) |-> !$past(cmd_in));
endmodule

// File: rtl/sdc_cmd_path.sv
module sdc_cmd_path import sdc_pkg::*; #(
  parameter int HALF_DIV  = 2,
  parameter int TIMEOUT   = 64,
  parameter int INIT_CLKS = 80,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  output logic [15:0]       status,
  output logic              busy,
  output logic [RSP_W-1:0]  rsp_regs,
  output logic              card_clk,
  output logic              cmd_out,
  output logic              cmd_oe,
  input  logic              cmd_in
);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_ARGL = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_ARGH = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h10);
  localparam int TW = $clog2(TIMEOUT) + 1;

  path_state_e  st;
  logic [15:0]  arg_lo, arg_hi;
  rsp_kind_e    kind_q;
  logic         need_q;
  logic         st_eoc, st_cto, st_ccrc;
  logic [TW-1:0] tmo;

  logic fall_tick, rise_tick;
  logic tx_done, rx_started, rx_done, rx_crc_ok;
  logic [RSP_W-1:0] rx_bits;

  logic         cmd_wr, tx_start, init_w;
  rsp_kind_e    kind_w;
  cmd_kind_e    ctype_w;
  logic [39:0]  body_w;
  logic [FRAME_W-1:0] frame_w;

  assign cmd_wr   = wr_en && (wr_addr == A_CMD);
  assign tx_start = cmd_wr && (st == ST_IDLE);
  assign init_w   = (wr_data == 16'h0080);
  assign kind_w   = rsp_kind_e'(wr_data[9:8]);
  assign ctype_w  = cmd_kind_e'(wr_data[13:12]);
  assign body_w   = {2'b01, wr_data[5:0], arg_hi, arg_lo};
  assign frame_w  = {body_w, crc7_of40(body_w), 1'b1};

  assign busy   = (st != ST_IDLE);
  assign status = {7'd0, st_ccrc, st_cto, 6'd0, st_eoc};

  sdc_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .card_clk(card_clk),
    .fall_tick(fall_tick), .rise_tick(rise_tick));

  sdc_cmd_tx #(.INIT_CLKS(INIT_CLKS)) u_tx (
    .clk(clk), .rst_n(rst_n), .fall_tick(fall_tick), .start(tx_start),
    .init_mode(init_w), .frame(frame_w), .cmd_bit(cmd_out),
    .cmd_oe(cmd_oe), .done(tx_done));

  sdc_rsp_rx u_rx (
    .clk(clk), .rst_n(rst_n), .rise_tick(rise_tick), .arm(st == ST_RX),
    .long_mode(kind_q == RSP_LONG), .cmd_in(cmd_in), .started(rx_started),
    .done(rx_done), .crc_ok(rx_crc_ok), .shreg(rx_bits));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      arg_lo   <= '0;
      arg_hi   <= '0;
      kind_q   <= RSP_NONE;
      need_q   <= 1'b0;
      st_eoc   <= 1'b0;
      st_cto   <= 1'b0;
      st_ccrc  <= 1'b0;
      tmo      <= '0;
      rsp_regs <= '0;
    end else begin
      if (wr_en && wr_addr == A_ARGL) arg_lo <= wr_data;
      if (wr_en && wr_addr == A_ARGH) arg_hi <= wr_data;
      if (wr_en && wr_addr == A_STAT) begin
        st_eoc  <= st_eoc  & ~wr_data[0];
        st_cto  <= st_cto  & ~wr_data[7];
        st_ccrc <= st_ccrc & ~wr_data[8];
      end
      case (st)
        ST_IDLE: if (tx_start) begin
          kind_q <= kind_w;
          need_q <= !init_w && (kind_w != RSP_NONE) && (ctype_w != CT_BC);
          st     <= ST_TX;
        end
        ST_TX: if (tx_done) begin
          if (need_q) begin
            tmo <= '0;
            st  <= ST_RX;
          end else begin
            st_eoc <= 1'b1;
            st     <= ST_IDLE;
          end
        end
        ST_RX: if (rx_done) begin
          if (kind_q == RSP_LONG) rsp_regs <= rx_bits;
          else                    rsp_regs <= {rx_bits[39:8], 96'd0};
          st_eoc <= 1'b1;
          if (kind_q != RSP_SHORT_NOCRC && !rx_crc_ok) st_ccrc <= 1'b1;
          st <= ST_IDLE;
        end else if (rise_tick && !rx_started) begin
          if (tmo == TW'(TIMEOUT - 1)) begin
            st_cto <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            tmo <= tmo + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: the line is only driven during a command
  a_r3_oe_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> busy);
  // R7: a CRC error is always reported with end of command
  a_r7_crc_with_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_ccrc) |-> st_eoc);
  // R9: a timeout never completes the command as well
  a_r9_tmo_alone: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_cto) |-> !$rose(st_eoc));
  // R11: a command word during a command leaves the latched kind alone
  a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(kind_q));
endmodule

// File: tb/test_sdc_cmd_path.sv
module test_sdc_cmd_path;
  localparam int HALF = 2, TMO = 16, INITN = 80;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n, wr_en, cmd_in;
  logic [7:0]   wr_addr;
  logic [15:0]  wr_data, status;
  logic         busy, card_clk, cmd_out, cmd_oe;
  logic [127:0] rsp_regs;

  sdc_cmd_path #(.HALF_DIV(HALF), .TIMEOUT(TMO), .INIT_CLKS(INITN)) i_sdc_cmd_path (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .status(status), .busy(busy), .rsp_regs(rsp_regs), .card_clk(card_clk),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in));

  int n_tests = 0, n_fail = 0, bursts_seen = 0;
  int exp_len[$];
  logic [47:0] exp_bits[$];

  task automatic chk(input string req, input logic ok, input logic [127:0] act, input logic [127:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  function automatic logic [6:0] tb_crc(input logic [135:0] v, input int hi, input int lo);
    logic [6:0] c = 7'd0;
    for (int i = hi; i >= lo; i--) begin
      logic f;
      f = v[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (f) c = c ^ 7'h09;
    end
    return c;
  endfunction

  // monitor: collects every driven burst and compares with the scoreboard
  int run_len = 0;
  logic [47:0] run_bits = '0;
  always @(posedge card_clk) begin
    if (cmd_oe) begin
      run_len++;
      run_bits = {run_bits[46:0], cmd_out};
    end else if (run_len > 0) begin
      if (exp_len.size() == 0) begin
        chk("R11 unexpected frame", 1'b0, 128'(run_len), 128'd0);
      end else begin
        int el;
        logic [47:0] eb;
        el = exp_len.pop_front();
        eb = exp_bits.pop_front();
        chk("R2 frame bits", run_bits == eb, 128'(run_bits), 128'(eb));
        chk("R3 burst length", run_len == el, 128'(run_len), 128'(el));
      end
      bursts_seen++;
      run_len = 0;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic issue(input logic [5:0] idx, input logic [1:0] ct, input logic [1:0] rt, input logic [31:0] arg);
    logic [39:0] body;
    body = {2'b01, idx, arg};
    wr(8'h04, arg[15:0]);
    wr(8'h08, arg[31:16]);
    exp_len.push_back(48);
    exp_bits.push_back({body, tb_crc(136'(body), 39, 0), 1'b1});
    wr(8'h00, {2'b00, ct, 2'b00, rt, 2'b00, idx});
  endtask

  task automatic respond(input int b0, input int n, input logic [135:0] bits);
    wait (bursts_seen == b0 + 1);
    repeat (2) @(negedge card_clk);
    for (int i = n - 1; i >= 0; i--) begin
      cmd_in = bits[i];
      @(negedge card_clk);
    end
    cmd_in = 1'b1;
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [47:0] short_rsp(input logic [5:0] idx, input logic [31:0] v, input logic bad);
    logic [39:0] b;
    logic [6:0]  c;
    b = {2'b00, idx, v};
    c = tb_crc(136'(b), 39, 0) ^ {6'd0, bad};
    return {b, c, 1'b1};
  endfunction

  function automatic logic [135:0] long_rsp(input logic [119:0] p, input logic bad);
    logic [6:0] c;
    c = tb_crc(136'(p), 119, 0) ^ {6'd0, bad};
    return {2'b00, 6'h3F, p, c, 1'b1};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog", 1'b0, 128'd0, 128'd1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int b0;
    logic [119:0] pay;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; cmd_in = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 status", status == 16'd0, 128'(status), 128'd0);
    chk("R1 busy/oe/out", {busy, cmd_oe, cmd_out} == 3'b001, 128'({busy, cmd_oe, cmd_out}), 128'd1);
    chk("R1 rsp", rsp_regs == '0, rsp_regs, 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4 initialisation clocks
    exp_len.push_back(INITN); exp_bits.push_back('1);
    wr(8'h00, 16'h0080);
    wait_idle();
    chk("R4 init eoc", status == 16'h0001, 128'(status), 128'h1);

    // R12 write-one-to-clear
    wr(8'h10, 16'h0001);
    @(negedge clk);
    chk("R12 clear", status == 16'h0000, 128'(status), 128'h0);

    // R10 no-response kind
    wr(8'h10, 16'hFFFF);
    issue(6'd0, 2'd2, 2'd0, 32'h0000_0000);
    wait_idle();
    chk("R10 no rsp", status == 16'h0001, 128'(status), 128'h1);

    // R10 broadcast kind with a response field set still does not wait
    wr(8'h10, 16'hFFFF);
    issue(6'd2, 2'd0, 2'd1, 32'h1234_5678);
    wait_idle();
    chk("R10 broadcast", status == 16'h0001, 128'(status), 128'h1);

    // R5 short response, good CRC
    wr(8'h10, 16'hFFFF);
    b0 = bursts_seen;
    issue(6'd17, 2'd2, 2'd1, 32'hA5A5_0F0F);
    respond(b0, 48, 136'(short_rsp(6'd17, 32'hDEAD_BEEF, 1'b0)));
    wait_idle();
    chk("R5 short status", status == 16'h0001, 128'(status), 128'h1);
    chk("R5 short packing", rsp_regs == {32'hDEAD_BEEF, 96'd0}, rsp_regs, {32'hDEAD_BEEF, 96'd0});

    // R7 short response, bad CRC
    wr(8'h10, 16'hFFFF);
    b0 = bursts_seen;
    issue(6'd13, 2'd2, 2'd1, 32'h0001_0000);
    respond(b0, 48, 136'(short_rsp(6'd13, 32'h0000_0900, 1'b1)));
    wait_idle();
    chk("R7 short crc err", status == 16'h0101, 128'(status), 128'h101);

    // R8 no-CRC kind with corrupted CRC
    wr(8'h10, 16'hFFFF);
    b0 = bursts_seen;
    issue(6'd41, 2'd1, 2'd3, 32'h00FF_8000);
    respond(b0, 48, 136'(short_rsp(6'h3F, 32'h80FF_8000, 1'b1)));
    wait_idle();
    chk("R8 no crc check", status == 16'h0001, 128'(status), 128'h1);
    chk("R8 packing", rsp_regs == {32'h80FF_8000, 96'd0}, rsp_regs, {32'h80FF_8000, 96'd0});

    // R6 long response, good CRC
    wr(8'h10, 16'hFFFF);
    pay = 120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32;
    b0 = bursts_seen;
    issue(6'd2, 2'd1, 2'd2, 32'h0);
    respond(b0, 136, long_rsp(pay, 1'b0));
    wait_idle();
    chk("R6 long status", status == 16'h0001, 128'(status), 128'h1);
    chk("R6 long packing", rsp_regs == long_rsp(pay, 1'b0)[127:0], rsp_regs, long_rsp(pay, 1'b0)[127:0]);

    // R7 long response, bad CRC
    wr(8'h10, 16'hFFFF);
    b0 = bursts_seen;
    issue(6'd9, 2'd2, 2'd2, 32'h5555_0000);
    respond(b0, 136, long_rsp(~pay, 1'b1));
    wait_idle();
    chk("R7 long crc err", status == 16'h0101, 128'(status), 128'h101);

    // R9 timeout: card stays silent
    wr(8'h10, 16'hFFFF);
    issue(6'd55, 2'd2, 2'd1, 32'hFFFF_FFFF);
    wait_idle();
    chk("R9 timeout", status == 16'h0080, 128'(status), 128'h80);

    // R11 command write during a command
    wr(8'h10, 16'hFFFF);
    b0 = bursts_seen;
    issue(6'd7, 2'd2, 2'd0, 32'h0000_0042);
    repeat (6) @(negedge clk);
    chk("R11 busy", busy == 1'b1, 128'(busy), 128'd1);
    wr(8'h00, 16'h0208);
    wait_idle();
    repeat (300) @(negedge clk);
    chk("R11 one frame", bursts_seen == b0 + 1, 128'(bursts_seen), 128'(b0 + 1));
    chk("R11 idle", busy == 1'b0 && cmd_oe == 1'b0, 128'({busy, cmd_oe}), 128'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule